// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block holds the single atomic reservation of a requester's load-linked / store-conditional pairs. Each completed memory operation is presented for one cycle with its byte address, its kind, the ID of the requester that issued it, and a flag that says whether the line is held in the tracked set. One cycle later the block reports a result. The result is 1 for every operation except a store-conditional that has lost its reservation, which reports 0.

A separate strobe reports that coherence permission was lost on a line. The reservation then drops if it covers that line. The reservation is one register holding a valid bit, a line address and an owner ID. A new load-linked replaces whatever was held before. A store-conditional always consumes the reservation on its line. A plain write by the owner also removes it.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (opKind 2'b10) to a present line reserves that line (address bits above LINE_OFF_W) for opId and reports success 1.
- R2: A store-conditional (opKind 2'b11) to a present line reports 1 only when that line is reserved and the stored owner equals opId, and reports 0 otherwise.
- R3: A store-conditional to a present line removes any reservation on that line, whether it succeeds or fails and whatever its ID.
- R4: An ordinary write (opKind 2'b01) to a present reserved line removes the reservation only when opId equals the owner. A write with another ID leaves it in place.
- R5: An operation with opPresent low reports success 1 and leaves the reservation unchanged.
- R6: A coherence-loss strobe on the reserved line removes the reservation. A loss on any other line has no effect.
- R7: A read (opKind 2'b00) always reports success 1 and never changes the reservation.
- R8: Only one reservation exists. A load-linked to a different line, or with a different ID, replaces it.
- R9: After reset no line is reserved, so a store-conditional fails until a load-linked is seen.
- R10: doneValid is high in exactly the cycle after an operation is presented, and low otherwise.
- R11: A loss strobe in the same cycle as an operation takes effect first. A store-conditional to that line fails, and a load-linked to it still leaves the line reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation completes this cycle |
| opKind | input | 2 | 00 read, 01 write, 10 load-linked, 11 store-conditional |
| opAddr | input | ADDR_W | Byte address of the operation |
| opId | input | ID_W | Requester ID of the operation |
| opPresent | input | 1 | The line is in the tracked set |
| lossValid | input | 1 | Coherence permission lost on a line this cycle |
| lossAddr | input | ADDR_W | Address of the line that was lost |
| doneValid | output | 1 | Result of the previous cycle's operation is valid |
| doneSuccess | output | 1 | 1 for success, 0 for a failed store-conditional |

## Verification
Random traffic runs over four lines with random byte offsets inside each line, four IDs, occasional absent lines and random loss strobes. This mix shows whether the line comparison ignores the offset bits and whether the owner comparison separates IDs. Directed sequences then check pairs that differ by one thing only: a store-conditional from the owner versus one from another ID, a write from the owner versus one from another ID, and a loss on the reserved line versus one on a neighbouring line. They also check a loss that lands in the same cycle as the store-conditional or load-linked it affects, which shows the order in which the two updates are applied.

// File: rtl/llsc_monitor_pkg.sv
package llsc_monitor_pkg;

  typedef enum logic [1:0] {
    OP_READ       = 2'b00,
    OP_WRITE      = 2'b01,
    OP_LOAD_LINK  = 2'b10,
    OP_STORE_COND = 2'b11
  } opKind_e;

  typedef struct packed {
    logic setRes;
    logic clearRes;
    logic respond;
    logic respOk;
  } resStrobe_t;

endpackage

// File: rtl/llsc_monitor_ctrl.sv
module llsc_monitor_ctrl
  import llsc_monitor_pkg::*;
(
  input  logic       opValid,
  input  logic [1:0] opKind,
  input  logic       opPresent,
  input  logic       lossValid,
  input  logic       lineHit,
  input  logic       ownerHit,
  input  logic       lossHit,
  output resStrobe_t strobe
);

  opKind_e kind;
  logic    lossKill;
  logic    live;
  logic    stillReserved;

  always_comb begin
    kind          = opKind_e'(opKind);
    lossKill      = lossValid && lossHit;
    live          = opValid && opPresent;
    stillReserved = lineHit && ownerHit && !lossKill;

    strobe.setRes   = live && (kind == OP_LOAD_LINK);
    strobe.clearRes = lossKill
                   || (live && (kind == OP_STORE_COND) && lineHit)
                   || (live && (kind == OP_WRITE) && lineHit && ownerHit);
    strobe.respond  = opValid;
    strobe.respOk   = !(live && (kind == OP_STORE_COND)) || stillReserved;
  end

endmodule

// File: rtl/llsc_monitor_dp.sv
module llsc_monitor_dp
  import llsc_monitor_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF_W = 6,
  parameter int ID_W       = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              opAddr,
  input  logic [ID_W-1:0]                opId,
  input  logic [ADDR_W-1:0]              lossAddr,
  input  resStrobe_t                     strobe,
  output logic                           lineHit,
  output logic                           ownerHit,
  output logic                           lossHit,
  output logic                           doneValid,
  output logic                           doneSuccess,
  output logic                           resValid,
  output logic [ADDR_W-LINE_OFF_W-1:0]   resLine,
  output logic [ID_W-1:0]                resOwner
);

  localparam int LINE_W = ADDR_W - LINE_OFF_W;

  logic [LINE_W-1:0] opLine;
  logic [LINE_W-1:0] lossLine;

  assign opLine   = opAddr[ADDR_W-1:LINE_OFF_W];
  assign lossLine = lossAddr[ADDR_W-1:LINE_OFF_W];

  assign lineHit  = resValid && (resLine == opLine);
  assign ownerHit = (resOwner == opId);
  assign lossHit  = resValid && (resLine == lossLine);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resLine  <= '0;
      resOwner <= '0;
    end else if (strobe.setRes) begin
      resValid <= 1'b1;
      resLine  <= opLine;
      resOwner <= opId;
    end else if (strobe.clearRes) begin
      resValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid   <= 1'b0;
      doneSuccess <= 1'b0;
    end else begin
      doneValid   <= strobe.respond;
      doneSuccess <= strobe.respond && strobe.respOk;
    end
  end

  // R1: a set strobe loads the op's line and ID
  p_set_loads_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setRes |=> resValid && (resLine == $past(opLine)) && (resOwner == $past(opId)));

  // R6: a loss that hits the line, without a set, empties the reservation
  p_loss_empties_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearRes && !strobe.setRes) |=> !resValid);

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_monitor_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF_W = 6,
  parameter int ID_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opKind,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [ID_W-1:0]   opId,
  input  logic              opPresent,
  input  logic              lossValid,
  input  logic [ADDR_W-1:0] lossAddr,
  output logic              doneValid,
  output logic              doneSuccess
);

  localparam int LINE_W = ADDR_W - LINE_OFF_W;

  resStrobe_t        strobe;
  logic              lineHit;
  logic              ownerHit;
  logic              lossHit;
  logic              resValid;
  logic [LINE_W-1:0] resLine;
  logic [ID_W-1:0]   resOwner;

  llsc_monitor_ctrl ctrl_i (
    .opValid   (opValid),
    .opKind    (opKind),
    .opPresent (opPresent),
    .lossValid (lossValid),
    .lineHit   (lineHit),
    .ownerHit  (ownerHit),
    .lossHit   (lossHit),
    .strobe    (strobe)
  );

  llsc_monitor_dp #(
    .ADDR_W     (ADDR_W),
    .LINE_OFF_W (LINE_OFF_W),
    .ID_W       (ID_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .opAddr      (opAddr),
    .opId        (opId),
    .lossAddr    (lossAddr),
    .strobe      (strobe),
    .lineHit     (lineHit),
    .ownerHit    (ownerHit),
    .lossHit     (lossHit),
    .doneValid   (doneValid),
    .doneSuccess (doneSuccess),
    .resValid    (resValid),
    .resLine     (resLine),
    .resOwner    (resOwner)
  );

  // R7: reads always report success
  p_read_ok_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 2'b00) |=> doneValid && doneSuccess);

  // R5: absent-line ops leave the reservation alone and succeed
  p_absent_keeps_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opPresent && !lossValid) |=> $stable(resValid) && doneSuccess);

  // R3: a store-conditional to the reserved line leaves nothing reserved
  p_sc_consumes_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opPresent && opKind == 2'b11 && lineHit) |=> !resValid);

  // R10: a result appears one cycle after each operation, and only then
  p_done_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> doneValid);
  p_no_spurious_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !doneValid);

endmodule

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb_top;

  localparam int ADDR_W     = 32;
  localparam int LINE_OFF_W = 6;
  localparam int ID_W       = 4;
  localparam int LINE_W     = ADDR_W - LINE_OFF_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              opValid = 1'b0;
  logic [1:0]        opKind = 2'b00;
  logic [ADDR_W-1:0] opAddr = '0;
  logic [ID_W-1:0]   opId = '0;
  logic              opPresent = 1'b0;
  logic              lossValid = 1'b0;
  logic [ADDR_W-1:0] lossAddr = '0;
  logic              doneValid;
  logic              doneSuccess;

  int checks = 0;
  int fails  = 0;

  logic              refValid = 1'b0;
  logic [LINE_W-1:0] refLine = '0;
  logic [ID_W-1:0]   refOwner = '0;

  always #5 clk = ~clk;

  llsc_monitor #(.ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W), .ID_W(ID_W)) dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .opAddr(opAddr),
    .opId(opId), .opPresent(opPresent), .lossValid(lossValid), .lossAddr(lossAddr),
    .doneValid(doneValid), .doneSuccess(doneSuccess)
  );

  function automatic logic [LINE_W-1:0] lineOf(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LINE_OFF_W];
  endfunction

  function automatic logic [ADDR_W-1:0] mkAddr(input int line, input int off);
    return ADDR_W'(line * (1 << LINE_OFF_W) + (off % (1 << LINE_OFF_W)));
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Present one cycle of stimulus, then compare the registered result
  task automatic step(input string tag, input logic v, input logic [1:0] k,
                      input logic [ADDR_W-1:0] a, input logic [ID_W-1:0] id,
                      input logic p, input logic lv, input logic [ADDR_W-1:0] la);
    logic expOk;
    opValid = v; opKind = k; opAddr = a; opId = id; opPresent = p;
    lossValid = lv; lossAddr = la;
    if (lv && refValid && refLine == lineOf(la)) refValid = 1'b0;
    expOk = 1'b1;
    if (v && p && k == 2'b11)
      expOk = refValid && refLine == lineOf(a) && refOwner == id;
    if (v && p) begin
      case (k)
        2'b10: begin refValid = 1'b1; refLine = lineOf(a); refOwner = id; end
        2'b11: if (refValid && refLine == lineOf(a)) refValid = 1'b0;
        2'b01: if (refValid && refLine == lineOf(a) && refOwner == id) refValid = 1'b0;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " R10 valid"}, doneValid, v);
    if (v) check(tag, doneSuccess, expOk);
    opValid = 1'b0; lossValid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R9 reset done", doneValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 idle", doneValid, 1'b0);

    step("R9 sc after reset", 1, 2'b11, mkAddr(1, 4), 4'd1, 1, 0, '0);
    step("R1 ll", 1, 2'b10, mkAddr(1, 8), 4'd1, 1, 0, '0);
    step("R2 sc owner", 1, 2'b11, mkAddr(1, 16), 4'd1, 1, 0, '0);
    step("R3 sc again", 1, 2'b11, mkAddr(1, 16), 4'd1, 1, 0, '0);
    step("R1 ll", 1, 2'b10, mkAddr(2, 0), 4'd1, 1, 0, '0);
    step("R2 sc other id", 1, 2'b11, mkAddr(2, 0), 4'd2, 1, 0, '0);
    step("R3 owner after foreign sc", 1, 2'b11, mkAddr(2, 0), 4'd1, 1, 0, '0);
    step("R1 ll", 1, 2'b10, mkAddr(3, 0), 4'd1, 1, 0, '0);
    step("R4 foreign write", 1, 2'b01, mkAddr(3, 4), 4'd2, 1, 0, '0);
    step("R4 sc kept", 1, 2'b11, mkAddr(3, 0), 4'd1, 1, 0, '0);
    step("R1 ll", 1, 2'b10, mkAddr(3, 0), 4'd1, 1, 0, '0);
    step("R4 owner write", 1, 2'b01, mkAddr(3, 4), 4'd1, 1, 0, '0);
    step("R4 sc cleared", 1, 2'b11, mkAddr(3, 0), 4'd1, 1, 0, '0);
    step("R1 ll", 1, 2'b10, mkAddr(0, 0), 4'd3, 1, 0, '0);
    step("R5 absent sc", 1, 2'b11, mkAddr(0, 0), 4'd3, 0, 0, '0);
    step("R5 absent ll", 1, 2'b10, mkAddr(2, 0), 4'd3, 0, 0, '0);
    step("R7 read", 1, 2'b00, mkAddr(0, 0), 4'd3, 1, 0, '0);
    step("R6 loss other line", 0, 2'b00, '0, 4'd0, 0, 1, mkAddr(1, 0));
    step("R5 R6 sc kept", 1, 2'b11, mkAddr(0, 0), 4'd3, 1, 0, '0);
    step("R1 ll", 1, 2'b10, mkAddr(0, 0), 4'd3, 1, 0, '0);
    step("R6 loss", 0, 2'b00, '0, 4'd0, 0, 1, mkAddr(0, 12));
    step("R6 sc after loss", 1, 2'b11, mkAddr(0, 0), 4'd3, 1, 0, '0);
    step("R1 ll", 1, 2'b10, mkAddr(1, 0), 4'd3, 1, 0, '0);
    step("R8 ll replaces", 1, 2'b10, mkAddr(2, 0), 4'd3, 1, 0, '0);
    step("R8 old line sc", 1, 2'b11, mkAddr(1, 0), 4'd3, 1, 0, '0);
    step("R1 ll", 1, 2'b10, mkAddr(2, 0), 4'd3, 1, 0, '0);
    step("R11 loss with sc", 1, 2'b11, mkAddr(2, 0), 4'd3, 1, 1, mkAddr(2, 8));
    step("R11 loss with ll", 1, 2'b10, mkAddr(2, 0), 4'd3, 1, 1, mkAddr(2, 8));
    step("R11 sc after", 1, 2'b11, mkAddr(2, 0), 4'd3, 1, 0, '0);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] k;
      string tag;
      k = 2'($urandom_range(0, 3));
      case (k)
        2'b00: tag = "R7 rand read";
        2'b01: tag = "R4 rand write";
        2'b10: tag = "R1 rand ll";
        default: tag = "R2 rand sc";
      endcase
      step(tag, ($urandom_range(0, 9) != 0), k,
           mkAddr($urandom_range(0, 3), $urandom_range(0, 63)),
           ID_W'($urandom_range(0, 3)), ($urandom_range(0, 6) != 0),
           ($urandom_range(0, 4) == 0),
           mkAddr($urandom_range(0, 3), $urandom_range(0, 63)));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule